// File: doc/BRIEF.md
# SMBus register-access slave

This block is a two-wire bus slave (SMBus / I2C style) that lets a host read and write a bank of eight 8-bit registers held in a separate register file. It watches the SCL and SDA lines using the system clock and detects START, repeated START and STOP conditions. It compares the 7-bit device address against a parameter and acknowledges the command and data bytes. It keeps a 3-bit register pointer. SDA is open-drain: the block only raises an output enable that pulls the line low.

A write is START, the device address with the direction bit at 0, a command byte and a data byte. The low three bits of the command become the pointer, and the data byte is written to the register that the pointer selects. A read sends the command the same way, then a repeated START and the address with the direction bit at 1. The slave then shifts out the register that the pointer selects. Word-sized transactions use the same byte register. A second written byte is acknowledged and then dropped. A read that the host acknowledges repeats the same register and does not move the pointer.

The register file is outside this block. It sees a pointer, write data and a one-cycle write strobe, and it returns the selected register on a combinational read port.

Top module: `smb_reg_slave`

## Requirements
- R1: During and right after reset, `sda_oe_o` is 0, `reg_we_o` is 0 and `reg_addr_o` is 0.
- R2: An address byte whose bits [7:1] equal `DEV_ADDR` is acknowledged by holding SDA low during the ninth clock. Bit 0 of that byte selects the direction: 0 means write and 1 means read.
- R3: A command byte that follows a write-direction address is acknowledged, and its bits [2:0] then appear as the pointer on `reg_addr_o`.
- R4: The first data byte after the command is acknowledged. It produces exactly one `reg_we_o` pulse of one cycle, with `reg_wdata_o` equal to the byte and `reg_addr_o` equal to the pointer. The pulse falls while the slave holds the acknowledge.
- R5: Every further data byte before STOP is acknowledged but causes no write.
- R6: After a read-direction address, the slave sends the register selected by the pointer, MSB first.
- R7: When the host acknowledges a sent byte, the next byte is the same register again, and the pointer does not change.
- R8: When the host does not acknowledge a sent byte, the slave releases SDA and drives nothing more until the next START.
- R9: An address byte whose bits [7:1] do not match gets no acknowledge. SDA stays released, and no write happens until the next START or STOP.
- R10: A STOP or START in the middle of a byte ends the transaction without writing. The pointer keeps its last completed value.
- R11: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr_o | output | 3 | Register pointer to the register file |
| reg_wdata_o | output | 8 | Write data to the register file |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Contents of the register at `reg_addr_o` |

## Verification
The assertions assume that each SCL level lasts several system clocks. They also assume that the host moves SDA only while SCL is low, except when it makes a START or STOP, and that the host never makes a START or STOP while the slave is pulling SDA low. The bench holds every SCL phase for five clocks. It changes SDA one clock after SCL falls and lets the line float for START and STOP only after the slave's acknowledge slot has ended. Under those conditions the checks hold: the enable moves only while SCL is low, and the strobe and pointer change only inside an acknowledge.

// File: rtl/smb_pkg.sv
// Shared types for the two-wire register-access slave.
// Assumes nothing beyond the widths chosen by the modules that use it.
package smb_pkg;

    // Transaction phase of the slave
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_TX,
        ST_TXACK,
        ST_SKIP
    } smb_state_e;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        BK_ADDR,
        BK_CMD,
        BK_DATA,
        BK_EXTRA
    } smb_byte_e;

    // Operation requested from the shift register
    typedef enum logic [2:0] {
        SH_NOP,
        SH_CLR,
        SH_LOAD,
        SH_IN,
        SH_OUT,
        SH_TICK
    } smb_shop_e;

    // Bus events decoded from the sampled lines
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } smb_evt_t;

endpackage

// File: rtl/smb_line_mon.sv
// Samples SCL and SDA with the system clock and decodes bus events:
// START, STOP, SCL rising edge, SCL falling edge, plus the sampled SDA.
// Assumes each line level lasts at least two clocks; no glitch filter.
module smb_line_mon
    import smb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output smb_evt_t evt_o
);

    logic scl_q, scl_qq, sda_q, sda_qq;

    // Two-deep history of both lines; reset to the idle (high) bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            scl_qq <= 1'b1;
            sda_q  <= 1'b1;
            sda_qq <= 1'b1;
        end else begin
            scl_q  <= scl_i;
            scl_qq <= scl_q;
            sda_q  <= sda_i;
            sda_qq <= sda_q;
        end
    end

    // Edge and condition decode from the history
    always_comb begin
        evt_o.start = scl_q & scl_qq & sda_qq & ~sda_q;
        evt_o.stop  = scl_q & scl_qq & ~sda_qq & sda_q;
        evt_o.rise  = scl_q & ~scl_qq;
        evt_o.fall  = ~scl_q & scl_qq;
        evt_o.sda   = sda_q;
    end

endmodule

// File: rtl/smb_shifter.sv
// Byte shift register with a bit counter. Shifts in at the LSB,
// shifts out from the MSB, loads in parallel, and counts clock ticks
// when transmitting. Assumes one operation per cycle from the controller.
module smb_shifter
    import smb_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  smb_shop_e     op_i,
    input  logic          bit_i,
    input  logic [W-1:0]  load_i,
    output logic [W-1:0]  data_o,
    output logic [CW-1:0] cnt_o
);

    logic [W-1:0]  data_q;
    logic [CW-1:0] cnt_q;

    // Apply the requested operation to data and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else begin
            case (op_i)
                SH_CLR: begin
                    data_q <= '0;
                    cnt_q  <= '0;
                end
                SH_LOAD: begin
                    data_q <= load_i;
                    cnt_q  <= '0;
                end
                SH_IN: begin
                    data_q <= {data_q[W-2:0], bit_i};
                    cnt_q  <= cnt_q + CW'(1);
                end
                SH_OUT:  data_q <= {data_q[W-2:0], 1'b0};
                SH_TICK: cnt_q  <= cnt_q + CW'(1);
                default: ;
            endcase
        end
    end

    assign data_o = data_q;
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/smb_xact_ctl.sv
// Transaction controller: address match, acknowledge timing, pointer,
// write strobe, and the read-data sequence with word repetition.
// Assumes events come from smb_line_mon and that the shifter applies the
// requested operation in the same cycle it is issued.
module smb_xact_ctl
    import smb_pkg::*;
#(
    parameter int          W        = 8,
    parameter int          PTR_W    = 3,
    parameter int          CW       = $clog2(W + 1),
    parameter logic [W-2:0] DEV_ADDR = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  smb_evt_t         evt_i,
    input  logic [W-1:0]     sh_data_i,
    input  logic [CW-1:0]    sh_cnt_i,
    input  logic [W-1:0]     rdata_i,
    output smb_shop_e        sh_op_o,
    output logic             sda_oe_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic             we_o,
    output logic [W-1:0]     wdata_o
);

    localparam logic [CW-1:0] FULL = CW'(W);

    smb_state_e       st_q, st_d;
    smb_byte_e        kind_q, kind_d;
    logic             oe_q, oe_d;
    logic             rw_q, rw_d;
    logic             we_q, we_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [W-1:0]     wdata_q, wdata_d;
    logic             byte_done, addr_hit;

    assign byte_done = (sh_cnt_i == FULL);
    assign addr_hit  = (sh_data_i[W-1:1] == DEV_ADDR);

    // Next-state and shifter-op decision for every bus event
    always_comb begin
        st_d    = st_q;
        kind_d  = kind_q;
        oe_d    = oe_q;
        rw_d    = rw_q;
        we_d    = 1'b0;
        ptr_d   = ptr_q;
        wdata_d = wdata_q;
        sh_op_o = SH_NOP;
        if (evt_i.start) begin
            st_d    = ST_RECV;
            kind_d  = BK_ADDR;
            oe_d    = 1'b0;
            sh_op_o = SH_CLR;
        end else if (evt_i.stop) begin
            st_d    = ST_IDLE;
            oe_d    = 1'b0;
            sh_op_o = SH_CLR;
        end else begin
            case (st_q)
                ST_RECV: begin
                    if (evt_i.rise && !byte_done) begin
                        sh_op_o = SH_IN;
                    end else if (evt_i.fall && byte_done) begin
                        if (kind_q == BK_ADDR && !addr_hit) begin
                            st_d = ST_SKIP;
                        end else begin
                            st_d = ST_ACK;
                            oe_d = 1'b1;
                            if (kind_q == BK_ADDR) rw_d = sh_data_i[0];
                        end
                    end
                end
                ST_ACK: begin
                    if (evt_i.rise) begin
                        if (kind_q == BK_CMD) ptr_d = sh_data_i[PTR_W-1:0];
                        if (kind_q == BK_DATA) begin
                            we_d    = 1'b1;
                            wdata_d = sh_data_i;
                        end
                    end else if (evt_i.fall) begin
                        if (kind_q == BK_ADDR && rw_q) begin
                            st_d    = ST_TX;
                            sh_op_o = SH_LOAD;
                            oe_d    = ~rdata_i[W-1];
                        end else begin
                            st_d    = ST_RECV;
                            sh_op_o = SH_CLR;
                            oe_d    = 1'b0;
                            case (kind_q)
                                BK_ADDR: kind_d = BK_CMD;
                                BK_CMD:  kind_d = BK_DATA;
                                default: kind_d = BK_EXTRA;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (evt_i.rise) begin
                        sh_op_o = SH_TICK;
                    end else if (evt_i.fall) begin
                        if (byte_done) begin
                            st_d = ST_TXACK;
                            oe_d = 1'b0;
                        end else begin
                            sh_op_o = SH_OUT;
                            oe_d    = ~sh_data_i[W-2];
                        end
                    end
                end
                ST_TXACK: begin
                    if (evt_i.rise && evt_i.sda) begin
                        st_d = ST_SKIP;
                    end else if (evt_i.fall) begin
                        st_d    = ST_TX;
                        sh_op_o = SH_LOAD;
                        oe_d    = ~rdata_i[W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            kind_q  <= BK_ADDR;
            oe_q    <= 1'b0;
            rw_q    <= 1'b0;
            we_q    <= 1'b0;
            ptr_q   <= '0;
            wdata_q <= '0;
        end else begin
            st_q    <= st_d;
            kind_q  <= kind_d;
            oe_q    <= oe_d;
            rw_q    <= rw_d;
            we_q    <= we_d;
            ptr_q   <= ptr_d;
            wdata_q <= wdata_d;
        end
    end

    assign sda_oe_o = oe_q;
    assign ptr_o    = ptr_q;
    assign we_o     = we_q;
    assign wdata_o  = wdata_q;

endmodule

// File: rtl/smb_reg_slave.sv
// Top of the two-wire register-access slave. Connects the line monitor,
// the byte shifter and the transaction controller. Assumes the register
// file returns the register at reg_addr_o combinationally on reg_rdata_i.
module smb_reg_slave
    import smb_pkg::*;
#(
    parameter int              DATA_W   = 8,
    parameter int              PTR_W    = 3,
    parameter logic [DATA_W-2:0] DEV_ADDR = 7'h4A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [PTR_W-1:0]  reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    smb_evt_t          evt;
    smb_shop_e         sh_op;
    logic [DATA_W-1:0] sh_data;
    logic [CNT_W-1:0]  sh_cnt;

    smb_line_mon line_i (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    smb_shifter #(.W(DATA_W), .CW(CNT_W)) shift_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (sh_op),
        .bit_i  (evt.sda),
        .load_i (reg_rdata_i),
        .data_o (sh_data),
        .cnt_o  (sh_cnt)
    );

    smb_xact_ctl #(
        .W        (DATA_W),
        .PTR_W    (PTR_W),
        .CW       (CNT_W),
        .DEV_ADDR (DEV_ADDR)
    ) ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .sh_data_i (sh_data),
        .sh_cnt_i  (sh_cnt),
        .rdata_i   (reg_rdata_i),
        .sh_op_o   (sh_op),
        .sda_oe_o  (sda_oe_o),
        .ptr_o     (reg_addr_o),
        .we_o      (reg_we_o),
        .wdata_o   (reg_wdata_o)
    );

endmodule

// File: rtl/smb_reg_slave_chk.sv
// Protocol checker for smb_reg_slave, attached by bind.
// Assumes SCL levels last several clocks, as stated in the brief.
module smb_reg_slave_chk #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe_o,
    input logic             reg_we_o,
    input logic [PTR_W-1:0] reg_addr_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe_o && !reg_we_o && reg_addr_o == '0));

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

    // R4
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    // R4
    we_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> sda_oe_o);

    // R3
    ptr_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_o != $past(reg_addr_o)) |-> sda_oe_o);

endmodule

bind smb_reg_slave smb_reg_slave_chk #(.PTR_W(PTR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o)
);

// File: tb/smb_reg_slave_tb_top.sv
// Scoreboard bench: driver tasks act as bus host and push expected
// register writes into a queue; a monitor pops them on each strobe.
module smb_reg_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PHASE      = 5;
    localparam logic [6:0] DEV = 7'h4A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_host = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       reg_we;
    logic [7:0] rf [8];
    logic [7:0] exp_rf [8];
    logic [10:0] wq [$];
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign sda_line = sda_host & ~sda_oe;

    smb_reg_slave dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .reg_addr_o  (reg_addr),
        .reg_wdata_o (reg_wdata),
        .reg_we_o    (reg_we),
        .reg_rdata_i (reg_rdata)
    );

    // Register file model in the environment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) rf[i] <= '0;
        end else if (reg_we) begin
            rf[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = rf[reg_addr];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected write per strobe
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (wq.size() == 0) begin
                check(1'b0, "R5 R9 R10 unexpected write", {reg_addr, reg_wdata}, 0);
            end else begin
                logic [10:0] e;
                e = wq.pop_front();
                check({reg_addr, reg_wdata} == e, "R4 write addr/data", {reg_addr, reg_wdata}, e);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        sda_host = b;
        wait_cyc(PHASE);
        scl = 1'b1;
        wait_cyc(PHASE);
        seen = sda_line;
        scl = 1'b0;
        wait_cyc(1);
    endtask

    task automatic bus_start();
        sda_host = 1'b1;
        wait_cyc(PHASE);
        scl = 1'b1;
        wait_cyc(PHASE);
        sda_host = 1'b0;
        wait_cyc(PHASE);
        scl = 1'b0;
        wait_cyc(1);
    endtask

    task automatic bus_stop();
        sda_host = 1'b0;
        wait_cyc(PHASE);
        scl = 1'b1;
        wait_cyc(PHASE);
        sda_host = 1'b1;
        wait_cyc(PHASE);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) bus_bit(v[i], s);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
        bus_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            v[i] = s;
        end
        bus_bit(~host_ack, s);
    endtask

    // Driver: full write, optional second (ignored) data byte
    task automatic wr_xact(input logic [7:0] cmd, input logic [7:0] d,
                           input bit extra, input logic [7:0] d2);
        logic ack;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        check(ack, "R2 write address ack", ack, 1);
        send_byte(cmd, ack);
        check(ack, "R3 command ack", ack, 1);
        wq.push_back({cmd[2:0], d});
        exp_rf[cmd[2:0]] = d;
        send_byte(d, ack);
        check(ack, "R4 data ack", ack, 1);
        if (extra) begin
            send_byte(d2, ack);
            check(ack, "R5 second data byte ack", ack, 1);
        end
        bus_stop();
        check(reg_addr == cmd[2:0], "R3 pointer from command", reg_addr, cmd[2:0]);
    endtask

    // Driver: command then repeated START and read n bytes
    task automatic rd_xact(input logic [7:0] cmd, input int n);
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        check(ack, "R2 address ack before read", ack, 1);
        send_byte(cmd, ack);
        check(ack, "R3 command ack before read", ack, 1);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        check(ack, "R2 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, v);
            if (k == 0) check(v == exp_rf[cmd[2:0]], "R6 read data", v, exp_rf[cmd[2:0]]);
            else        check(v == exp_rf[cmd[2:0]], "R7 repeated read data", v, exp_rf[cmd[2:0]]);
        end
        check(reg_addr == cmd[2:0], "R7 pointer unchanged by read", reg_addr, cmd[2:0]);
    endtask

    initial begin
        logic ack;
        logic s;
        logic [7:0] v;
        for (int i = 0; i < 8; i++) exp_rf[i] = '0;
        wait_cyc(4);
        check(!sda_oe, "R1 reset sda_oe", sda_oe, 0);
        check(!reg_we, "R1 reset we", reg_we, 0);
        check(reg_addr == 3'd0, "R1 reset pointer", reg_addr, 0);
        rst_n = 1'b1;
        wait_cyc(4);

        // Byte write; command upper bits ignored for the pointer
        wr_xact(8'hF5, 8'hA5, 1'b0, 8'h00);
        // Word write: second byte acked, dropped
        wr_xact(8'h02, 8'h3C, 1'b1, 8'h77);

        // Byte read of reg 5 with host NACK
        rd_xact(8'h05, 1);
        check(!sda_oe, "R8 released after NACK", sda_oe, 0);
        for (int i = 0; i < 9; i++) begin
            bus_bit(1'b1, s);
            check(s, "R8 no drive after NACK", s, 1);
        end
        bus_stop();

        // Word read of reg 2: same byte twice
        rd_xact(8'h02, 2);
        bus_stop();

        // Wrong address: no ack anywhere, no write
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, ack);
        check(!ack, "R9 mismatched address not acked", ack, 0);
        send_byte(8'h03, ack);
        check(!ack, "R9 command after mismatch not acked", ack, 0);
        send_byte(8'h99, ack);
        check(!ack, "R9 data after mismatch not acked", ack, 0);
        bus_stop();
        check(rf[3] == 8'h00, "R9 register untouched", rf[3], 0);

        // Set pointer to 6, then abort a command mid-byte by STOP
        wr_xact(8'h06, 8'h5A, 1'b0, 8'h00);
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_bits(8'h00, 4);
        bus_stop();
        check(reg_addr == 3'd6, "R10 pointer kept after STOP abort", reg_addr, 6);

        // Abort a data byte by repeated START, then read directly
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h02, ack);
        send_bits(8'hFF, 5);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        check(ack, "R10 read address ack after START abort", ack, 1);
        recv_byte(1'b0, v);
        check(v == 8'h3C, "R10 no write and pointer kept", v, 8'h3C);
        bus_stop();
        wait_cyc(4);

        check(wq.size() == 0, "R4 all expected writes seen", wq.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule